// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Cartridge Window

This block sits behind a cartridge bus and exposes a 128-word by 16-bit serial EEPROM through a single memory-mapped port byte. Software never issues whole commands. Instead it writes the port byte over and over, raising and lowering chip select and the serial clock and presenting the data-in bit. It then reads the same byte back to sample data-out. Internally a bit-level state machine frames the start bit, a 10-bit command and an optional 16-bit data phase. It keeps a write-enable latch and holds the 256-byte storage in flops, which start at all ones.

Access to the window is guarded by two independent unlock registers, each set by one magic byte in its own address range. The block also decodes the ROM bank select register, whose value is presented directly as an output. A few neighbouring sensor registers in the window return fixed constants.

Top module: `cart_eeprom_window`

## Requirements
- R1: The window at 0xA000-0xBFFF is open only while both unlocks are set: 0x0A last written to 0x0000-0x1FFF and 0x40 last written to 0x4000-0x5FFF. While closed, every window read returns 0xFF and port writes leave the port state unchanged. Both unlocks are clear after reset.
- R2: Writing any value other than the magic byte to an unlock range clears that unlock only.
- R3: A write to 0x2000-0x3FFF loads `rom_bank` with data bits 6:0 on the next clock, and a value of 0 stays 0. After reset `rom_bank` is 1.
- R4: While the window is open, reads of offsets 0x20-0x2F and 0x40-0x4F return 0xFF. Offsets 0x30-0x3F and 0x50-0x5F return 0x07, offsets 0x60-0x6F return 0x00, and any other offset except the port returns 0xFF.
- R5: The port sits at window offsets 0x80-0x8F, with bit 7 chip select, bit 6 clock, bit 1 data-in and bit 0 data-out. A write that raises chip select returns the state machine to idle. If the same write also raises the clock with data-in high, that edge counts as a start bit.
- R6: In idle, a clock rise with data-in high is the start bit. The next 10 rising edges shift data-in in, newest bit into bit 0. Of the 10 bits, bits 9:8 are the opcode: 01 write, 10 read, 11 erase, 00 extended. Bits 6:0 are the word address, and bit 7 is ignored except in the extended group.
- R7: An extended command with bits 7:6 equal to 11 sets the write-enable latch, and one with 00 clears it. The latch is clear after reset. While it is clear, write, erase, write-all and erase-all change no word.
- R8: After a write command, 16 further clock rises shift in a word, MSB first. On the 16th rise the word is stored at the address and the machine returns to idle.
- R9: An erase command sets the addressed word to 0xFFFF on the command's last clock.
- R10: An extended command with bits 7:6 equal to 01 (write-all) stores the next 16 shifted bits into every word. One with 10 (erase-all) sets every word to 0xFFFF at once.
- R11: A read command drives data-out to 0 on the command's last clock. Each of the next 16 clock rises then presents the addressed word one bit at a time, MSB first, and the machine returns to idle after the 16th bit.
- R12: A port write that lowers the clock while chip select stays high keeps the previous data-out. Every other port write that changes neither state nor data-out leaves data-out reading 1, including any write with chip select low.
- R13: A port read returns bits 7:1 as last written, with the current data-out in bit 0. After reset it reads 0x01, and all storage words read 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle bus write strobe |
| bus_addr | input | 16 | Bus address for reads and writes |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| rom_bank | output | BANK_BITS (7) | Selected ROM bank |

## Verification
The closest collision is a single port write that raises chip select and the clock together with data-in high. That write must first cancel whatever transfer was in flight and then take the same edge as a fresh start bit. The bench provokes it by aborting a write command halfway through its data phase. It then uses one combined write to start a read of the same address. The result is judged by the read returning the untouched 0xFFFF, together with a correct dummy zero and a correct 16-bit readout. A second pairing is a read that decodes on the same edge as the storage lookup. The bench checks this through the dummy zero, which must be followed directly by the stored MSB.

// File: rtl/sew_pkg.sv
package sew_pkg;

   typedef enum logic [4:0] {
      ST_IDLE  = 5'h00,
      ST_CMD   = 5'h01,
      ST_DOUT  = 5'h02,
      ST_WDIS  = 5'h10,
      ST_WALL  = 5'h11,
      ST_EALL  = 5'h12,
      ST_WEN   = 5'h13,
      ST_WRITE = 5'h14,
      ST_READ  = 5'h18,
      ST_ERASE = 5'h1C
   } sew_state_e;

   localparam int PB_CS  = 7;
   localparam int PB_CLK = 6;
   localparam int PB_DI  = 1;
   localparam int PB_DO  = 0;

   localparam logic [7:0] UNLOCK_A_KEY = 8'h0A;
   localparam logic [7:0] UNLOCK_B_KEY = 8'h40;

endpackage

// File: rtl/sew_gate.sv
module sew_gate #(
   parameter int          BANK_BITS  = 7,
   parameter logic [7:0]  BANK_RESET = 8'h01
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [2:0]           region,
   input  logic [7:0]           bus_wdata,
   output logic                 open,
   output logic [BANK_BITS-1:0] rom_bank
);
   import sew_pkg::*;

   generate
      if (BANK_BITS < 1 || BANK_BITS > 8) begin : g_bad_bank
         $fatal(1, "sew_gate: BANK_BITS must be 1..8");
      end
   endgenerate

   logic unlock_a_q, unlock_b_q;
   logic [BANK_BITS-1:0] bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlock_a_q <= 1'b0;
         unlock_b_q <= 1'b0;
         bank_q     <= BANK_RESET[BANK_BITS-1:0];
      end else if (bus_wr) begin
         case (region)
            3'd0:    unlock_a_q <= (bus_wdata == UNLOCK_A_KEY);
            3'd1:    bank_q     <= bus_wdata[BANK_BITS-1:0];
            3'd2:    unlock_b_q <= (bus_wdata == UNLOCK_B_KEY);
            default: ;
         endcase
      end
   end

   assign open     = unlock_a_q & unlock_b_q;
   assign rom_bank = bank_q;

   // R3
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && region == 3'd1) |=> (rom_bank == $past(bus_wdata[BANK_BITS-1:0])));

   // R2
   unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && region == 3'd0 && bus_wdata != UNLOCK_A_KEY) |=> !open);

endmodule

// File: rtl/sew_store.sv
module sew_store #(
   parameter int ADDR_BITS = 7,
   parameter int WORD_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_one,
   input  logic [ADDR_BITS-1:0] wr_addr,
   input  logic [WORD_BITS-1:0] wr_data,
   input  logic                 fill,
   input  logic [WORD_BITS-1:0] fill_data,
   input  logic [ADDR_BITS-1:0] rd_addr,
   output logic [WORD_BITS-1:0] rd_word
);
   localparam int WORDS = 1 << ADDR_BITS;
   localparam int LANES = WORD_BITS / 8;

   generate
      if (WORD_BITS % 8 != 0) begin : g_bad_word
         $fatal(1, "sew_store: WORD_BITS must be a whole number of bytes");
      end
   endgenerate

   // Lane 0 carries the most significant byte (byte address 2*addr).
   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam int HI = WORD_BITS - 1 - 8 * ln;
      logic [7:0] bytes_q [WORDS];

      always_ff @(posedge clk) begin
         for (int w = 0; w < WORDS; w++) begin
            if (!rst_n)
               bytes_q[w] <= 8'hFF;
            else if (fill)
               bytes_q[w] <= fill_data[HI -: 8];
            else if (wr_one && wr_addr == ADDR_BITS'(w))
               bytes_q[w] <= wr_data[HI -: 8];
         end
      end

      assign rd_word[HI -: 8] = bytes_q[rd_addr];
   end

   // R10
   fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill && wr_one));

endmodule

// File: rtl/sew_serial.sv
module sew_serial #(
   parameter int ADDR_BITS = 7,
   parameter int WORD_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 port_wr,
   input  logic [7:0]           port_wdata,
   output logic [7:0]           port_q,
   output logic                 wr_one,
   output logic [ADDR_BITS-1:0] wr_addr,
   output logic [WORD_BITS-1:0] wr_data,
   output logic                 fill,
   output logic [WORD_BITS-1:0] fill_data,
   output logic [ADDR_BITS-1:0] rd_addr,
   input  logic [WORD_BITS-1:0] rd_word
);
   import sew_pkg::*;

   localparam int CMD_BITS = ADDR_BITS + 3;
   localparam int CNT_MAX  = (CMD_BITS > WORD_BITS) ? CMD_BITS : WORD_BITS;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   generate
      if (ADDR_BITS < 2) begin : g_bad_addr
         $fatal(1, "sew_serial: ADDR_BITS must be at least 2");
      end
      if (WORD_BITS < CMD_BITS) begin : g_bad_sr
         $fatal(1, "sew_serial: WORD_BITS must hold a whole command");
      end
   endgenerate

   sew_state_e           state_q, st;
   logic [WORD_BITS-1:0] sr_q, sr;
   logic [CNT_W-1:0]     cnt_q, cnt;
   logic [ADDR_BITS-1:0] addr_q, addr;
   logic                 we_q, we;
   logic [7:0]           port_n;
   logic                 cs_rise, clk_rise, clk_fall;

   function automatic sew_state_e decode(input logic [1:0] op, input logic [1:0] ext);
      case (op)
         2'b01:   decode = ST_WRITE;
         2'b10:   decode = ST_READ;
         2'b11:   decode = ST_ERASE;
         default: begin
            case (ext)
               2'b00:   decode = ST_WDIS;
               2'b01:   decode = ST_WALL;
               2'b10:   decode = ST_EALL;
               default: decode = ST_WEN;
            endcase
         end
      endcase
   endfunction

   always_comb begin
      port_n    = port_wdata | 8'h01;
      st        = state_q;
      sr        = sr_q;
      cnt       = cnt_q;
      addr      = addr_q;
      we        = we_q;
      wr_one    = 1'b0;
      wr_data   = sr_q;
      fill      = 1'b0;
      fill_data = '1;
      cs_rise   = !port_q[PB_CS]  && port_n[PB_CS];
      clk_rise  = !port_q[PB_CLK] && port_n[PB_CLK];
      clk_fall  =  port_q[PB_CLK] && !port_n[PB_CLK];
      if (port_wr) begin
         if (cs_rise) st = ST_IDLE;
         if (clk_rise) begin
            if (st == ST_CMD || st == ST_WRITE || st == ST_WALL) begin
               sr  = {sr[WORD_BITS-2:0], port_n[PB_DI]};
               cnt = cnt + 1'b1;
            end
            case (st)
               ST_IDLE: begin
                  if (port_n[PB_DI]) begin
                     st  = ST_CMD;
                     cnt = '0;
                     sr  = '0;
                  end
               end
               ST_CMD: begin
                  if (cnt == CNT_W'(CMD_BITS)) begin
                     st   = decode(sr[CMD_BITS-1 -: 2], sr[CMD_BITS-3 -: 2]);
                     cnt  = '0;
                     addr = sr[ADDR_BITS-1:0];
                  end
               end
               ST_DOUT: begin
                  port_n[PB_DO] = sr[WORD_BITS-1];
                  sr  = {sr[WORD_BITS-2:0], 1'b0};
                  cnt = cnt - 1'b1;
                  if (cnt == '0) st = ST_IDLE;
               end
               default: ;
            endcase
            case (st)
               ST_WEN: begin
                  we = 1'b1;
                  st = ST_IDLE;
               end
               ST_WDIS: begin
                  we = 1'b0;
                  st = ST_IDLE;
               end
               ST_WRITE: begin
                  if (cnt == CNT_W'(WORD_BITS)) begin
                     wr_one  = we_q;
                     wr_data = sr;
                     st      = ST_IDLE;
                  end
               end
               ST_ERASE: begin
                  wr_one  = we_q;
                  wr_data = '1;
                  st      = ST_IDLE;
               end
               ST_READ: begin
                  cnt           = CNT_W'(WORD_BITS);
                  sr            = rd_word;
                  st            = ST_DOUT;
                  port_n[PB_DO] = 1'b0;
               end
               ST_WALL: begin
                  if (cnt == CNT_W'(WORD_BITS)) begin
                     fill      = we_q;
                     fill_data = sr;
                     st        = ST_IDLE;
                  end
               end
               ST_EALL: begin
                  fill      = we_q;
                  fill_data = '1;
                  st        = ST_IDLE;
               end
               default: ;
            endcase
         end else if (port_n[PB_CS] && clk_fall) begin
            port_n[PB_DO] = port_q[PB_DO];
         end
      end
   end

   assign wr_addr = addr;
   assign rd_addr = addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sr_q    <= '0;
         cnt_q   <= '0;
         addr_q  <= '0;
         we_q    <= 1'b0;
         port_q  <= 8'h01;
      end else if (port_wr) begin
         state_q <= st;
         sr_q    <= sr;
         cnt_q   <= cnt;
         addr_q  <= addr;
         we_q    <= we;
         port_q  <= port_n;
      end
   end

   // R5
   cs_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && !port_q[PB_CS] && port_wdata[PB_CS] && port_q[PB_CLK]) |=> (state_q == ST_IDLE));

   // R7
   guarded_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_one || fill) |-> we_q);

   // R11
   dout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DOUT) |-> (cnt_q != '0));

   // R12
   float_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && !port_wdata[PB_CS]) |=> port_q[PB_DO]);

endmodule

// File: rtl/cart_eeprom_window.sv
module cart_eeprom_window #(
   parameter int          ADDR_BITS  = 7,
   parameter int          WORD_BITS  = 16,
   parameter int          BANK_BITS  = 7,
   parameter logic [7:0]  BANK_RESET = 8'h01,
   parameter logic [3:0]  PORT_SLOT  = 4'h8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [15:0]          bus_addr,
   input  logic [7:0]           bus_wdata,
   output logic [7:0]           bus_rdata,
   output logic [BANK_BITS-1:0] rom_bank
);
   localparam logic [2:0] WIN_REGION = 3'd5;

   logic                 open;
   logic                 in_win, port_sel, port_wr;
   logic [7:0]           port_q;
   logic                 wr_one, fill;
   logic [ADDR_BITS-1:0] wr_addr, rd_addr;
   logic [WORD_BITS-1:0] wr_data, fill_data, rd_word;
   logic                 unused_addr_bits;

   assign unused_addr_bits = ^{bus_addr[12:8], bus_addr[3:0]};
   assign in_win   = (bus_addr[15:13] == WIN_REGION);
   assign port_sel = in_win && (bus_addr[7:4] == PORT_SLOT);
   assign port_wr  = bus_wr && port_sel && open;

   sew_gate #(.BANK_BITS(BANK_BITS), .BANK_RESET(BANK_RESET)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .region    (bus_addr[15:13]),
      .bus_wdata (bus_wdata),
      .open      (open),
      .rom_bank  (rom_bank)
   );

   sew_serial #(.ADDR_BITS(ADDR_BITS), .WORD_BITS(WORD_BITS)) u_serial (
      .clk        (clk),
      .rst_n      (rst_n),
      .port_wr    (port_wr),
      .port_wdata (bus_wdata),
      .port_q     (port_q),
      .wr_one     (wr_one),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .fill       (fill),
      .fill_data  (fill_data),
      .rd_addr    (rd_addr),
      .rd_word    (rd_word)
   );

   sew_store #(.ADDR_BITS(ADDR_BITS), .WORD_BITS(WORD_BITS)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_one    (wr_one),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .fill      (fill),
      .fill_data (fill_data),
      .rd_addr   (rd_addr),
      .rd_word   (rd_word)
   );

   always_comb begin
      bus_rdata = 8'hFF;
      if (in_win && open) begin
         case (bus_addr[7:4])
            4'h3, 4'h5: bus_rdata = 8'h07;
            4'h6:       bus_rdata = 8'h00;
            PORT_SLOT:  bus_rdata = port_q;
            default:    bus_rdata = 8'hFF;
         endcase
      end
   end

   // R1
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && port_sel && !open) |=> $stable(port_q));

endmodule

// File: tb/cart_eeprom_window_test.sv
module cart_eeprom_window_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic [6:0]  rom_bank;

   int checks = 0;
   int errors = 0;
   logic [15:0] shadow [128];
   logic        we_model = 1'b0;

   cart_eeprom_window uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_bank(rom_bank)
   );

   always #10 clk = ~clk;

   initial begin
      #3000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] fixed_exp(input logic [3:0] slot);
      if (slot == 4'h3 || slot == 4'h5) return 8'h07;
      if (slot == 4'h6) return 8'h00;
      return 8'hFF;
   endfunction

   task automatic bw(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic br(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic port(input logic cs, input logic ck, input logic di);
      bw(16'hA080, {cs, ck, 4'b0000, di, 1'b0});
   endtask

   task automatic sbit(input logic b);
      port(1'b1, 1'b0, b);
      port(1'b1, 1'b1, b);
   endtask

   task automatic begin_cmd(input logic [1:0] op, input logic [7:0] a, input logic merged);
      if (merged) begin
         port(1'b0, 1'b0, 1'b0);
         port(1'b1, 1'b1, 1'b1);
      end else begin
         port(1'b0, 1'b0, 1'b0);
         port(1'b1, 1'b0, 1'b0);
         sbit(1'b1);
      end
      for (int i = 1; i >= 0; i--) sbit(op[i]);
      for (int i = 7; i >= 0; i--) sbit(a[i]);
   endtask

   task automatic end_cmd();
      port(1'b0, 1'b0, 1'b0);
   endtask

   task automatic ee_write(input logic [6:0] a, input logic [15:0] d);
      begin_cmd(2'b01, {1'b0, a}, 1'b0);
      for (int i = 15; i >= 0; i--) sbit(d[i]);
      end_cmd();
      if (we_model) shadow[a] = d;
   endtask

   task automatic ee_erase(input logic [6:0] a);
      begin_cmd(2'b11, {1'b0, a}, 1'b0);
      end_cmd();
      if (we_model) shadow[a] = 16'hFFFF;
   endtask

   task automatic ee_ext(input logic [1:0] sub);
      begin_cmd(2'b00, {sub, 6'h00}, 1'b0);
      end_cmd();
      if (sub == 2'b11) we_model = 1'b1;
      if (sub == 2'b00) we_model = 1'b0;
      if (sub == 2'b10 && we_model) for (int i = 0; i < 128; i++) shadow[i] = 16'hFFFF;
   endtask

   task automatic ee_wall(input logic [15:0] d);
      begin_cmd(2'b00, 8'h40, 1'b0);
      for (int i = 15; i >= 0; i--) sbit(d[i]);
      end_cmd();
      if (we_model) for (int i = 0; i < 128; i++) shadow[i] = d;
   endtask

   // Returns word, dummy bit and the number of falling edges that lost data-out.
   task automatic ee_read(input logic [6:0] a, input logic merged,
                          output logic [15:0] d, output logic dummy, output int holdbad);
      logic [7:0] r;
      holdbad = 0;
      begin_cmd(2'b10, {1'b1, a}, merged);
      br(16'hA080, r);
      dummy = r[0];
      for (int i = 15; i >= 0; i--) begin
         logic prev;
         prev = (i == 15) ? dummy : d[i+1];
         port(1'b1, 1'b0, 1'b0);
         br(16'hA080, r);
         if (r[0] !== prev) holdbad++;
         port(1'b1, 1'b1, 1'b0);
         br(16'hA080, r);
         d[i] = r[0];
      end
      end_cmd();
   endtask

   initial begin
      logic [7:0]  r;
      logic [15:0] w;
      logic        dm;
      int          hb;
      void'($urandom(32'd7));
      for (int i = 0; i < 128; i++) shadow[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset: window closed
      br(16'hA080, r); chk("R1 locked read after reset", r, 8'hFF);
      chk("R3 bank reset", rom_bank, 7'h01);
      // R3 no remap, bit 7 dropped
      bw(16'h2000, 8'h85); chk("R3 bank 0x85", rom_bank, 7'h05);
      bw(16'h3FFF, 8'h00); chk("R3 bank zero kept", rom_bank, 7'h00);
      // R1 one unlock only
      bw(16'h0000, 8'h0A);
      br(16'hA080, r); chk("R1 half unlocked", r, 8'hFF);
      bw(16'h4000, 8'h40);
      br(16'hA080, r); chk("R13 port reset value", r, 8'h01);
      // R2 wrong value clears matching unlock
      bw(16'h5000, 8'h41);
      br(16'hA080, r); chk("R2 second unlock cleared", r, 8'hFF);
      // R1 writes ignored while closed
      bw(16'hA080, 8'hC2);
      bw(16'h4000, 8'h40);
      br(16'hA080, r); chk("R1 locked write ignored", r, 8'h01);
      bw(16'h1000, 8'h0B);
      br(16'hA080, r); chk("R2 first unlock cleared", r, 8'hFF);
      bw(16'h0000, 8'h0A);
      // R4 fixed registers
      for (int s = 0; s < 16; s++) begin
         if (s != 8) begin
            br({8'hA0, 4'(s), 4'h3}, r);
            chk($sformatf("R4 slot %0h", s), r, fixed_exp(4'(s)));
         end
      end
      // R13 readback of control bits
      bw(16'hA080, 8'h3C);
      br(16'hA08F, r); chk("R13 readback low cs", r, 8'h3D);
      end_cmd();
      br(16'hA080, r); chk("R12 idle data-out high", r, 8'h01);
      // R13 initial storage, R11 dummy bit
      ee_read(7'd5, 1'b0, w, dm, hb);
      chk("R13 initial word", w, 16'hFFFF);
      chk("R11 dummy zero", dm, 1'b0);
      // R7 writes blocked with latch clear
      ee_write(7'd5, 16'h1234);
      ee_erase(7'd6);
      ee_read(7'd5, 1'b0, w, dm, hb); chk("R7 write blocked", w, 16'hFFFF);
      // R8 write then read
      ee_ext(2'b11);
      ee_write(7'd5, 16'h1234);
      ee_write(7'd127, 16'hABCD);
      ee_read(7'd5, 1'b0, w, dm, hb); chk("R8 word 5", w, 16'h1234);
      chk("R12 falling edge hold", hb, 0);
      ee_read(7'd127, 1'b0, w, dm, hb); chk("R6 top address", w, 16'hABCD);
      chk("R11 dummy then MSB", {dm, w[15]}, 2'b01);
      // R9 erase
      ee_erase(7'd5);
      ee_read(7'd5, 1'b0, w, dm, hb); chk("R9 erased", w, 16'hFFFF);
      ee_read(7'd127, 1'b0, w, dm, hb); chk("R9 neighbour kept", w, 16'hABCD);
      // R5 abort a write mid-data, then a merged cs+clk start
      begin_cmd(2'b01, 8'h09, 1'b0);
      for (int i = 0; i < 8; i++) sbit(1'b0);
      ee_read(7'd9, 1'b1, w, dm, hb);
      chk("R5 aborted write left word", w, 16'hFFFF);
      chk("R5 merged start dummy", dm, 1'b0);
      ee_read(7'd127, 1'b1, w, dm, hb); chk("R5 merged start read", w, 16'hABCD);
      // R10 write-all and erase-all
      ee_wall(16'h5A5A);
      ee_read(7'd0, 1'b0, w, dm, hb);   chk("R10 write-all word 0", w, 16'h5A5A);
      ee_read(7'd127, 1'b0, w, dm, hb); chk("R10 write-all word 127", w, 16'h5A5A);
      ee_ext(2'b10);
      ee_read(7'd64, 1'b0, w, dm, hb);  chk("R10 erase-all", w, 16'hFFFF);
      // R7 disable then write-all ignored
      ee_ext(2'b00);
      ee_wall(16'h0000);
      ee_read(7'd33, 1'b0, w, dm, hb);  chk("R7 write-all blocked", w, 16'hFFFF);
      // Random mix against the shadow
      ee_ext(2'b11);
      for (int n = 0; n < 40; n++) begin
         logic [6:0]  a;
         logic [15:0] d;
         int          op;
         a  = 7'($urandom);
         d  = 16'($urandom);
         op = $urandom_range(0, 9);
         if (op < 5)      ee_write(a, d);
         else if (op < 7) ee_erase(a);
         else if (op < 8) ee_ext(($urandom_range(0, 1) == 0) ? 2'b00 : 2'b11);
         ee_read(a, 1'b0, w, dm, hb);
         chk($sformatf("R8 random word %0d", a), w, shadow[a]);
         chk("R12 random hold", hb, 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule